// File: doc/BRIEF.md
# Attribute-Driven Set-Associative Data Cache Controller

This block sits between a load/store pipeline and the external memory side of a small data cache. For every access it reads a set of memory attributes that travel with the request: cacheable, shared, write-allocate and write-through. From these it decides whether the cache is looked up at all, whether a miss claims a line, and whether a store is copied out to external memory at once or held in the line as dirty data until that line is replaced.

Tags, valid and dirty state and line data are kept in internal arrays. The default geometry is 4 ways by 16 sets, with lines of 8 words of 32 bits. External traffic leaves on three ports. A single-beat bypass port carries uncached accesses, non-allocating store misses and write-through copies. A line-fetch port returns a whole line in one handshake. A victim port hands a dirty line to an eviction buffer. Only one miss or bypass is in flight at a time, and `req_ready` holds the pipeline off until it completes.

Top module: `attr_cache_ctrl`

## Requirements
- R1: An access made while `cache_en` is low, or with `req_cacheable` low, or with `req_shared` high, goes out as one beat on the bypass port. It does not fetch a line and does not read or change cached contents, even when the address is resident.
- R2: A read miss on a cacheable, non-shared access fetches the whole line once and returns the requested word. Later reads to any word of that line hit with no fetch.
- R3: A store miss with `req_walloc` high fetches the line and merges the store into it. With `req_walloc` low, the store is issued once on the bypass port (`byp_write`=1) and no line is fetched.
- R4: A store hit with `req_wthru` high updates the cached word and also issues the same store once on the bypass port.
- R5: A store hit with `req_wthru` low updates the cached word and marks the line dirty. No external store is issued, and later reads return the new value.
- R6: When a line is allocated, the lowest-numbered invalid way of the set is used if one exists. Otherwise the victim comes from a per-set round-robin pointer that advances by one, wrapping, after each replacement in a full set.
- R7: A dirty victim is presented on the eviction port with its line address (offset bits zero) and full contents, held until `evict_done`, before the new line is requested. A clean victim is dropped with no eviction.
- R8: `req_ready` is low from the cycle after a miss or bypass is accepted until its response, so at most one such access is outstanding.
- R9: After reset, `req_ready` is high and `rsp_valid`, `byp_valid`, `fill_req` and `evict_valid` are low. No line is valid.
- R10: Each accepted access produces exactly one `rsp_valid` pulse. A read hit responds in the cycle right after acceptance, with its data on `rsp_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cache_en | input | 1 | Global cache enable |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | AW | Byte address |
| req_wdata | input | DW | Store data |
| req_cacheable | input | 1 | Access attribute: cacheable |
| req_shared | input | 1 | Access attribute: shared |
| req_walloc | input | 1 | Access attribute: allocate on store miss |
| req_wthru | input | 1 | Access attribute: write-through (0 = write-back) |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Load data |
| byp_valid | output | 1 | Single-beat external access pending |
| byp_write | output | 1 | Bypass beat is a store |
| byp_addr | output | AW | Bypass address |
| byp_wdata | output | DW | Bypass store data |
| byp_done | input | 1 | Bypass beat complete |
| byp_rdata | input | DW | Bypass load data |
| fill_req | output | 1 | Line fetch request |
| fill_addr | output | AW | Line-aligned fetch address |
| fill_done | input | 1 | Fetched line valid on fill_data |
| fill_data | input | WORDS*DW | Fetched line, word 0 in low bits |
| evict_valid | output | 1 | Dirty victim offered to eviction buffer |
| evict_addr | output | AW | Line-aligned victim address |
| evict_data | output | WORDS*DW | Victim contents, word 0 in low bits |
| evict_done | input | 1 | Eviction buffer took the victim |

## Verification
A tag, valid or dirty bit held wrongly shows up at the ports on the next access to that set. A lost allocation turns an expected hit into a fetch one cycle after acceptance, and a spurious hit returns stale data with no fetch. A lost dirty bit stays hidden until that line is chosen as a victim, so the scenarios push a dirty line out through the round-robin order and then read it back from the external model. A round-robin pointer that is off by one is exposed by which resident line misses when a full set is refilled.

// File: rtl/attr_cache_pkg.sv
package attr_cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BYP   = 2'd1,
    ST_EVICT = 2'd2,
    ST_FILL  = 2'd3
  } acc_state_e;

  // next round-robin slot, wrapping at n
  function automatic int unsigned rr_next(input int unsigned cur, input int unsigned n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/acc_tag_store.sv
module acc_tag_store #(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  parameter int TAGW = 23
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [$clog2(SETS)-1:0]        rd_set,
  output logic [WAYS-1:0]                rd_valid,
  output logic [WAYS-1:0]                rd_dirty,
  output logic [WAYS-1:0][TAGW-1:0]      rd_tags,
  output logic [$clog2(WAYS)-1:0]        rd_rr,
  input  logic                           wr_en,
  input  logic [$clog2(SETS)-1:0]        wr_set,
  input  logic [$clog2(WAYS)-1:0]        wr_way,
  input  logic [TAGW-1:0]                wr_tag,
  input  logic                           wr_dirty,
  input  logic                           rr_adv
);
  import attr_cache_pkg::*;
  localparam int WAYW = $clog2(WAYS);

  logic [WAYS-1:0] vld_q [SETS];
  logic [WAYS-1:0] drt_q [SETS];
  logic [WAYW-1:0] rr_q  [SETS];
  logic [TAGW-1:0] tag_q [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        drt_q[s] <= '0;
        rr_q[s]  <= '0;
      end
    end else if (wr_en) begin
      vld_q[wr_set][wr_way] <= 1'b1;
      drt_q[wr_set][wr_way] <= wr_dirty;
      if (rr_adv) rr_q[wr_set] <= WAYW'(rr_next(int'(rr_q[wr_set]), WAYS));
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_set][wr_way] <= wr_tag;
  end

  assign rd_valid = vld_q[rd_set];
  assign rd_dirty = drt_q[rd_set];
  assign rd_rr    = rr_q[rd_set];

  for (genvar w = 0; w < WAYS; w++) begin : g_tag_rd
    assign rd_tags[w] = tag_q[rd_set][w];
  end
endmodule

// File: rtl/acc_data_store.sv
module acc_data_store #(
  parameter int WAYS  = 4,
  parameter int SETS  = 16,
  parameter int WORDS = 8,
  parameter int DW    = 32
) (
  input  logic                       clk,
  input  logic [$clog2(SETS)-1:0]    rd_set,
  input  logic [$clog2(WAYS)-1:0]    rd_way,
  output logic [WORDS*DW-1:0]        rd_line,
  input  logic                       wr_en,
  input  logic [$clog2(SETS)-1:0]    wr_set,
  input  logic [$clog2(WAYS)-1:0]    wr_way,
  input  logic [WORDS-1:0]           wr_mask,
  input  logic [WORDS*DW-1:0]        wr_line
);
  localparam int LINES = SETS * WAYS;
  localparam int LW    = WORDS * DW;

  logic [LW-1:0] line_q [LINES];

  function automatic int slot(input int s, input int w);
    return s * WAYS + w;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int k = 0; k < WORDS; k++) begin
        if (wr_mask[k])
          line_q[slot(int'(wr_set), int'(wr_way))][k*DW +: DW] <= wr_line[k*DW +: DW];
      end
    end
  end

  assign rd_line = line_q[slot(int'(rd_set), int'(rd_way))];
endmodule

// File: rtl/attr_cache_ctrl.sv
module attr_cache_ctrl #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int WAYS  = 4,
  parameter int SETS  = 16,
  parameter int WORDS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cache_en,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [AW-1:0]        req_addr,
  input  logic [DW-1:0]        req_wdata,
  input  logic                 req_cacheable,
  input  logic                 req_shared,
  input  logic                 req_walloc,
  input  logic                 req_wthru,
  output logic                 rsp_valid,
  output logic [DW-1:0]        rsp_rdata,
  output logic                 byp_valid,
  output logic                 byp_write,
  output logic [AW-1:0]        byp_addr,
  output logic [DW-1:0]        byp_wdata,
  input  logic                 byp_done,
  input  logic [DW-1:0]        byp_rdata,
  output logic                 fill_req,
  output logic [AW-1:0]        fill_addr,
  input  logic                 fill_done,
  input  logic [WORDS*DW-1:0]  fill_data,
  output logic                 evict_valid,
  output logic [AW-1:0]        evict_addr,
  output logic [WORDS*DW-1:0]  evict_data,
  input  logic                 evict_done
);
  import attr_cache_pkg::*;

  localparam int WAYW = $clog2(WAYS);
  localparam int SETW = $clog2(SETS);
  localparam int OFFW = $clog2(WORDS);
  localparam int BYTW = $clog2(DW / 8);
  localparam int TAGW = AW - SETW - OFFW - BYTW;
  localparam int LW   = WORDS * DW;

  // address arithmetic
  function automatic logic [SETW-1:0] set_of(input logic [AW-1:0] a);
    return a[BYTW+OFFW +: SETW];
  endfunction
  function automatic logic [TAGW-1:0] tag_of(input logic [AW-1:0] a);
    return a[AW-1 -: TAGW];
  endfunction
  function automatic logic [OFFW-1:0] word_of(input logic [AW-1:0] a);
    return a[BYTW +: OFFW];
  endfunction
  function automatic logic [AW-1:0] line_base(input logic [TAGW-1:0] t, input logic [SETW-1:0] s);
    return {t, s, {(OFFW+BYTW){1'b0}}};
  endfunction

  acc_state_e      state_q;
  logic [AW-1:0]   sv_addr;
  logic [DW-1:0]   sv_wdata;
  logic            sv_write, sv_wthru, sv_full;
  logic [WAYW-1:0] sv_way;

  logic            idle;
  logic [AW-1:0]   look_addr;
  logic [SETW-1:0] look_set;
  logic [WAYS-1:0] t_valid, t_dirty, hit_vec;
  logic [WAYS-1:0][TAGW-1:0] t_tags;
  logic [WAYW-1:0] t_rr, hit_way, vict_way;
  logic            hit, all_valid, bypass_cond;
  logic [LW-1:0]   rd_line, fill_merge;
  logic [DW-1:0]   rd_word;

  // named internal events
  logic ev_accept, ev_byp, ev_hit, ev_miss_alloc, ev_miss_noalloc, ev_fill_done;

  // tag / data store write controls
  logic            tw_en, tw_dirty, tw_rr;
  logic [TAGW-1:0] tw_tag;
  logic            dw_en;
  logic [WORDS-1:0] dw_mask;
  logic [LW-1:0]   dw_line;
  logic [WAYW-1:0] acc_way;

  assign idle      = (state_q == ST_IDLE);
  assign look_addr = idle ? req_addr : sv_addr;
  assign look_set  = set_of(look_addr);

  acc_tag_store #(.WAYS(WAYS), .SETS(SETS), .TAGW(TAGW)) u_tags (
    .clk(clk), .rst_n(rst_n), .rd_set(look_set),
    .rd_valid(t_valid), .rd_dirty(t_dirty), .rd_tags(t_tags), .rd_rr(t_rr),
    .wr_en(tw_en), .wr_set(look_set), .wr_way(acc_way), .wr_tag(tw_tag),
    .wr_dirty(tw_dirty), .rr_adv(tw_rr)
  );

  acc_data_store #(.WAYS(WAYS), .SETS(SETS), .WORDS(WORDS), .DW(DW)) u_data (
    .clk(clk), .rd_set(look_set), .rd_way(acc_way), .rd_line(rd_line),
    .wr_en(dw_en), .wr_set(look_set), .wr_way(acc_way),
    .wr_mask(dw_mask), .wr_line(dw_line)
  );

  // lookup, hit encode and victim choice
  always_comb begin
    hit_way  = '0;
    vict_way = t_rr;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = t_valid[w] && (t_tags[w] == tag_of(look_addr));
      if (hit_vec[w]) hit_way = WAYW'(w);
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!t_valid[w]) vict_way = WAYW'(w);
    end
  end
  assign hit       = |hit_vec;
  assign all_valid = &t_valid;
  assign acc_way   = idle ? hit_way : sv_way;
  assign rd_word   = rd_line[word_of(req_addr)*DW +: DW];

  assign bypass_cond     = !cache_en || !req_cacheable || req_shared;
  assign ev_accept       = req_valid && idle;
  assign ev_byp          = ev_accept && bypass_cond;
  assign ev_hit          = ev_accept && !bypass_cond && hit;
  assign ev_miss_alloc   = ev_accept && !bypass_cond && !hit && (!req_write || req_walloc);
  assign ev_miss_noalloc = ev_accept && !bypass_cond && !hit && req_write && !req_walloc;
  assign ev_fill_done    = (state_q == ST_FILL) && fill_done;

  always_comb begin
    fill_merge = fill_data;
    if (sv_write) fill_merge[word_of(sv_addr)*DW +: DW] = sv_wdata;
  end

  always_comb begin
    tw_en = 1'b0; tw_tag = tag_of(look_addr); tw_dirty = 1'b0; tw_rr = 1'b0;
    dw_en = 1'b0; dw_mask = '0; dw_line = {WORDS{req_wdata}};
    if (ev_hit && req_write) begin
      dw_en = 1'b1;
      dw_mask[word_of(req_addr)] = 1'b1;
      if (!req_wthru) begin
        tw_en    = 1'b1;
        tw_dirty = 1'b1;
      end
    end else if (ev_fill_done) begin
      tw_en    = 1'b1;
      tw_dirty = sv_write && !sv_wthru;
      tw_rr    = sv_full;
      dw_en    = 1'b1;
      dw_mask  = '1;
      dw_line  = fill_merge;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      sv_addr   <= '0;
      sv_wdata  <= '0;
      sv_write  <= 1'b0;
      sv_wthru  <= 1'b0;
      sv_full   <= 1'b0;
      sv_way    <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (ev_accept) begin
          sv_addr  <= req_addr;
          sv_wdata <= req_wdata;
          sv_write <= req_write;
          sv_wthru <= req_wthru;
          sv_full  <= all_valid;
          sv_way   <= vict_way;
          if (ev_byp || ev_miss_noalloc || (ev_hit && req_write && req_wthru)) begin
            state_q <= ST_BYP;
          end else if (ev_hit) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= rd_word;
          end else begin
            state_q <= (t_valid[vict_way] && t_dirty[vict_way]) ? ST_EVICT : ST_FILL;
          end
        end
        ST_BYP: if (byp_done) begin
          rsp_valid <= 1'b1;
          rsp_rdata <= byp_rdata;
          state_q   <= ST_IDLE;
        end
        ST_EVICT: if (evict_done) state_q <= ST_FILL;
        ST_FILL: if (fill_done) begin
          if (sv_write && sv_wthru) begin
            state_q <= ST_BYP;
          end else begin
            rsp_valid <= 1'b1;
            rsp_rdata <= fill_data[word_of(sv_addr)*DW +: DW];
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready   = idle;
  assign byp_valid   = (state_q == ST_BYP);
  assign byp_write   = sv_write;
  assign byp_addr    = sv_addr;
  assign byp_wdata   = sv_wdata;
  assign fill_req    = (state_q == ST_FILL);
  assign fill_addr   = line_base(tag_of(sv_addr), set_of(sv_addr));
  assign evict_valid = (state_q == ST_EVICT);
  assign evict_addr  = line_base(t_tags[sv_way], set_of(sv_addr));
  assign evict_data  = rd_line;
endmodule

// File: rtl/attr_cache_chk.sv
module attr_cache_chk (
  input logic clk,
  input logic rst_n,
  input logic cache_en,
  input logic req_valid,
  input logic req_ready,
  input logic req_write,
  input logic req_cacheable,
  input logic req_shared,
  input logic req_wthru,
  input logic rsp_valid,
  input logic byp_valid,
  input logic fill_req,
  input logic evict_valid,
  input logic evict_done,
  input logic ev_hit
);
  // R1
  byp_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (!cache_en || !req_cacheable || req_shared)) |=> (byp_valid && !fill_req));

  // R8
  busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req || evict_valid || byp_valid) |-> !req_ready);

  // R7
  evict_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |-> !fill_req);

  // R7
  evict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evict_valid && !evict_done) |=> evict_valid);

  // R5
  wb_hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_hit && req_write && !req_wthru) |=> (rsp_valid && !byp_valid));

  // R10
  rd_hit_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_hit && !req_write) |=> rsp_valid);
endmodule

bind attr_cache_ctrl attr_cache_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cache_en(cache_en),
  .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
  .req_cacheable(req_cacheable), .req_shared(req_shared), .req_wthru(req_wthru),
  .rsp_valid(rsp_valid), .byp_valid(byp_valid), .fill_req(fill_req),
  .evict_valid(evict_valid), .evict_done(evict_done), .ev_hit(ev_hit)
);

// File: tb/attr_cache_ctrl_test.sv
module attr_cache_ctrl_test;
  localparam int WORDS = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cache_en = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic req_cacheable = 1'b0, req_shared = 1'b0, req_walloc = 1'b0, req_wthru = 1'b0;
  logic req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic byp_valid, byp_write, byp_done;
  logic [31:0] byp_addr, byp_wdata, byp_rdata;
  logic fill_req, fill_done;
  logic [31:0] fill_addr;
  logic [WORDS*32-1:0] fill_data, evict_data;
  logic evict_valid, evict_done;
  logic [31:0] evict_addr;

  always #4 clk = ~clk;  // 125 MHz

  attr_cache_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cache_en(cache_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_cacheable(req_cacheable),
    .req_shared(req_shared), .req_walloc(req_walloc), .req_wthru(req_wthru),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .byp_valid(byp_valid), .byp_write(byp_write), .byp_addr(byp_addr),
    .byp_wdata(byp_wdata), .byp_done(byp_done), .byp_rdata(byp_rdata),
    .fill_req(fill_req), .fill_addr(fill_addr), .fill_done(fill_done), .fill_data(fill_data),
    .evict_valid(evict_valid), .evict_addr(evict_addr), .evict_data(evict_data),
    .evict_done(evict_done)
  );

  // external memory model
  logic [31:0] mem [logic [31:0]];
  int n_byp_rd = 0, n_byp_wr = 0, n_fill = 0, n_evict = 0, evict_at_fill = 0;
  logic [31:0] last_evict = '0;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return a ^ 32'h5A5A_0000;
  endfunction
  function automatic logic [31:0] mrd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : pat(a);
  endfunction
  // address: tag above bit 9, set in bits 8..5, word in bits 4..2
  function automatic logic [31:0] mk(input int t, input int s, input int w);
    return (32'(t) << 9) | (32'(s) << 5) | (32'(w) << 2);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      byp_done <= 1'b0; fill_done <= 1'b0; evict_done <= 1'b0;
      byp_rdata <= '0; fill_data <= '0;
    end else begin
      byp_done   <= byp_valid && !byp_done;
      fill_done  <= fill_req && !fill_done;
      evict_done <= evict_valid && !evict_done;
      if (byp_valid && !byp_done) begin
        if (byp_write) begin mem[byp_addr] = byp_wdata; n_byp_wr++; end
        else begin byp_rdata <= mrd(byp_addr); n_byp_rd++; end
      end
      if (fill_req && !fill_done) begin
        for (int k = 0; k < WORDS; k++) fill_data[k*32 +: 32] <= mrd(fill_addr + 32'(k*4));
        n_fill++;
        evict_at_fill = n_evict;
      end
      if (evict_valid && !evict_done) begin
        for (int k = 0; k < WORDS; k++) mem[evict_addr + 32'(k*4)] = evict_data[k*32 +: 32];
        last_evict = evict_addr;
        n_evict++;
      end
    end
  end

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [31:0] rd;
  logic first_rsp, rdy_after;

  task automatic access(input logic wr, input logic [31:0] a, input logic [31:0] d,
                        input logic cach, input logic sh, input logic wa, input logic wt);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_write = wr; req_addr = a; req_wdata = d;
    req_cacheable = cach; req_shared = sh; req_walloc = wa; req_wthru = wt;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    first_rsp = rsp_valid;
    rdy_after = req_ready;
    while (!rsp_valid) @(negedge clk);
    rd = rsp_rdata;
  endtask

  task automatic t_reset();
    check(req_ready == 1'b1, "R9 ready", 32'(req_ready), 1);
    check(rsp_valid == 1'b0, "R9 rsp", 32'(rsp_valid), 0);
    check({byp_valid, fill_req, evict_valid} == 3'b000, "R9 ports idle",
          {29'd0, byp_valid, fill_req, evict_valid}, 0);
  endtask

  task automatic t_bypass();
    int f0, b0;
    f0 = n_fill; b0 = n_byp_rd;
    cache_en = 1'b0;
    access(0, mk(1,0,0), 0, 1, 0, 0, 0);
    check(rd == pat(mk(1,0,0)), "R1 disabled data", rd, pat(mk(1,0,0)));
    cache_en = 1'b1;
    access(0, mk(1,0,0), 0, 0, 0, 0, 0);
    access(0, mk(1,0,0), 0, 1, 1, 0, 0);
    check(n_byp_rd - b0 == 3, "R1 bypass reads", 32'(n_byp_rd - b0), 3);
    check(n_fill == f0, "R1 no fetch", 32'(n_fill - f0), 0);
    check(rdy_after == 1'b0, "R8 ready low on bypass", 32'(rdy_after), 0);
    access(0, mk(1,0,0), 0, 1, 0, 0, 0);
    check(n_fill - f0 == 1, "R2 not allocated by bypass", 32'(n_fill - f0), 1);
  endtask

  task automatic t_read_alloc();
    int f0;
    f0 = n_fill;
    access(0, mk(2,1,5), 0, 1, 0, 0, 0);
    check(rd == pat(mk(2,1,5)), "R2 miss data", rd, pat(mk(2,1,5)));
    check(rdy_after == 1'b0, "R8 ready low on miss", 32'(rdy_after), 0);
    access(0, mk(2,1,3), 0, 1, 0, 0, 0);
    check(rd == pat(mk(2,1,3)), "R2 hit data", rd, pat(mk(2,1,3)));
    check(n_fill - f0 == 1, "R2 single fetch", 32'(n_fill - f0), 1);
    check(first_rsp == 1'b1, "R10 hit next cycle", 32'(first_rsp), 1);
  endtask

  task automatic t_write_noalloc();
    int f0, w0;
    f0 = n_fill; w0 = n_byp_wr;
    access(1, mk(3,2,1), 32'hDEAD_0001, 1, 0, 0, 0);
    check(n_byp_wr - w0 == 1, "R3 no-alloc store external", 32'(n_byp_wr - w0), 1);
    check(n_fill == f0, "R3 no-alloc no fetch", 32'(n_fill - f0), 0);
    check(mrd(mk(3,2,1)) == 32'hDEAD_0001, "R3 memory written", mrd(mk(3,2,1)), 32'hDEAD_0001);
    access(0, mk(3,2,1), 0, 1, 0, 0, 0);
    check(n_fill - f0 == 1 && rd == 32'hDEAD_0001, "R3 line not allocated", rd, 32'hDEAD_0001);
  endtask

  task automatic t_write_alloc_wb();
    int f0, w0;
    f0 = n_fill; w0 = n_byp_wr;
    access(1, mk(4,3,2), 32'hB0B0_0002, 1, 0, 1, 0);
    check(n_fill - f0 == 1, "R3 alloc store fetch", 32'(n_fill - f0), 1);
    access(0, mk(4,3,2), 0, 1, 0, 0, 0);
    check(rd == 32'hB0B0_0002, "R3 merged word", rd, 32'hB0B0_0002);
    access(1, mk(4,3,6), 32'hB0B0_0006, 1, 0, 0, 0);
    check(n_byp_wr == w0, "R5 no external store", 32'(n_byp_wr - w0), 0);
    check(mrd(mk(4,3,6)) == pat(mk(4,3,6)), "R5 memory untouched", mrd(mk(4,3,6)), pat(mk(4,3,6)));
    access(0, mk(4,3,6), 0, 1, 0, 0, 0);
    check(rd == 32'hB0B0_0006 && n_fill - f0 == 1, "R5 read back", rd, 32'hB0B0_0006);
  endtask

  task automatic t_write_through();
    int f0, w0;
    f0 = n_fill; w0 = n_byp_wr;
    access(1, mk(2,1,5), 32'hC0DE_0005, 1, 0, 0, 1);
    check(n_byp_wr - w0 == 1, "R4 external copy", 32'(n_byp_wr - w0), 1);
    check(mrd(mk(2,1,5)) == 32'hC0DE_0005, "R4 memory value", mrd(mk(2,1,5)), 32'hC0DE_0005);
    access(0, mk(2,1,5), 0, 1, 0, 0, 0);
    check(rd == 32'hC0DE_0005 && n_fill == f0, "R4 cache updated", rd, 32'hC0DE_0005);
  endtask

  task automatic t_evict();
    int f0, e0;
    e0 = n_evict;
    // set 3: way0 = tag4 (dirty); fill ways 1..3 with tags 5,6,7
    for (int t = 5; t <= 7; t++) access(0, mk(t,3,0), 0, 1, 0, 0, 0);
    check(n_evict == e0, "R6 invalid ways first", 32'(n_evict - e0), 0);
    f0 = n_fill;
    access(0, mk(8,3,1), 0, 1, 0, 0, 0);   // victim way0 dirty
    check(n_evict - e0 == 1, "R7 dirty victim evicted", 32'(n_evict - e0), 1);
    check(last_evict == mk(4,3,0), "R7 victim address", last_evict, mk(4,3,0));
    check(mrd(mk(4,3,6)) == 32'hB0B0_0006, "R7 victim data", mrd(mk(4,3,6)), 32'hB0B0_0006);
    check(evict_at_fill == n_evict, "R7 evict before fetch", 32'(evict_at_fill), 32'(n_evict));
    check(rd == pat(mk(8,3,1)), "R2 data after evict", rd, pat(mk(8,3,1)));
    access(0, mk(9,3,0), 0, 1, 0, 0, 0);   // victim way1 (tag5) clean
    check(n_evict - e0 == 1, "R7 clean victim dropped", 32'(n_evict - e0), 1);
    access(0, mk(7,3,0), 0, 1, 0, 0, 0);   // way3 still resident
    check(n_fill - f0 == 2, "R6 round robin keeps way3", 32'(n_fill - f0), 2);
    access(0, mk(5,3,0), 0, 1, 0, 0, 0);   // miss, victim way2 (tag6)
    access(0, mk(6,3,0), 0, 1, 0, 0, 0);   // miss: way2 was replaced
    check(n_fill - f0 == 4, "R6 way2 then way3 replaced", 32'(n_fill - f0), 4);
    access(0, mk(4,3,2), 0, 1, 0, 0, 0);
    check(rd == 32'hB0B0_0002, "R7 written-back data refetched", rd, 32'hB0B0_0002);
  endtask

  task automatic t_disabled_resident();
    int f0, w0;
    f0 = n_fill; w0 = n_byp_wr;
    cache_en = 1'b0;
    access(1, mk(2,1,0), 32'hFACE_0000, 1, 0, 1, 0);
    check(n_byp_wr - w0 == 1, "R1 disabled store external", 32'(n_byp_wr - w0), 1);
    cache_en = 1'b1;
    access(0, mk(2,1,0), 0, 1, 0, 0, 0);
    check(rd == pat(mk(2,1,0)) && n_fill == f0, "R1 cache line untouched", rd, pat(mk(2,1,0)));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bypass();
    t_read_alloc();
    t_write_noalloc();
    t_write_alloc_wb();
    t_write_through();
    t_evict();
    t_disabled_resident();
    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule